// File: doc/BRIEF.md
# Phase Accumulator with Offset and Clear

This block is the numerically controlled phase source of a direct digital synthesizer. A wide accumulator advances by a frequency tuning word on every clock, and a narrower phase offset is added to its most significant bits to give the phase that addresses a downstream sine table. Tuning word and offset come in as already-buffered words. They are copied into the active registers only on an update strobe, so a new tone or phase step starts on a known cycle. Repeatedly loading new offsets through the strobe gives phase modulation.

Two zeroing controls are provided. A level-held continuous clear keeps the accumulator at zero for as long as it is high. An auto-clear bit makes every update strobe reset the accumulator to zero, after which it runs again from the freshly loaded tuning word. The output phase is combinational from the active registers, so it reflects the state left by the most recent clock edge.

Top module: `phase_accum_core`

## Requirements
- R1: After rst_ni is asserted low, the accumulator, the active tuning word and the active offset are all zero, so phase_o reads 0.
- R2: On each clock with no clear, the accumulator adds the active tuning word modulo 2^32; it wraps silently past 0xFFFFFFFF.
- R3: A value on ftw_i has no effect while update_i is low; it becomes the active tuning word at the edge where update_i is high and is first added on the following edge.
- R4: phase_o equals accumulator bits [31:18] plus the active offset, modulo 2^14 (offset in degrees = offset*360/2^14).
- R5: A value on pow_i has no effect while update_i is low; it becomes the active offset at the edge where update_i is high, so a new offset per strobe steps phase_o at that edge (phase modulation).
- R6: While cont_clr_i is high at an edge, the accumulator is zero after that edge; accumulation resumes at the first edge with it low.
- R7: Continuous clear takes priority over accumulation and auto-clear, and update strobes still load both active words while it is high.
- R8: When auto_clr_i and update_i are both high at an edge, the accumulator is zero after that edge and the new tuning word is added from the next edge on; this repeats on every strobe while auto_clr_i stays high.
- R9: auto_clr_i high without update_i leaves accumulation unchanged, and update_i with auto_clr_i low loads words without zeroing the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ftw_i | input | 32 | Buffered frequency tuning word |
| pow_i | input | 14 | Buffered phase offset word |
| cont_clr_i | input | 1 | Continuous accumulator clear, level |
| auto_clr_i | input | 1 | Zero accumulator on each update strobe when high |
| update_i | input | 1 | Update strobe: load buffered words |
| phase_o | output | 14 | Offset phase to sine lookup |

## Verification
A corrupted accumulator shows at phase_o on the very next edge, because the output is a direct sum of registered state; a slip in the low accumulator bits surfaces only once carries reach bit 18, so the bench uses tuning words large enough to move the top bits every cycle. A word loaded a cycle early or late, or a clear that fires on the wrong strobe, shifts the whole phase sequence by one step and is caught on the first compared cycle after the strobe. Each cycle's expected phase is queued by the driver and compared one edge later.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int unsigned ACC_W_D = 32;
  localparam int unsigned PH_W_D  = 14;
endpackage

// File: rtl/pa_word_buf.sv
module pa_word_buf #(
  parameter int unsigned ACC_W = pa_pkg::ACC_W_D,
  parameter int unsigned PH_W  = pa_pkg::PH_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [PH_W-1:0]  pow_i,
  output logic [ACC_W-1:0] ftw_o,
  output logic [PH_W-1:0]  pow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_o <= '0;
      pow_o <= '0;
    end else if (upd_i) begin
      ftw_o <= ftw_i;
      pow_o <= pow_i;
    end
  end

  a_r3_words_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(ftw_o) && $stable(pow_o)));
  a_r7_words_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (ftw_o == $past(ftw_i) && pow_o == $past(pow_i)));
endmodule

// File: rtl/pa_accum.sv
module pa_accum #(
  parameter int unsigned ACC_W = pa_pkg::ACC_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic             cont_clr_i,
  input  logic             auto_clr_i,
  input  logic             upd_i,
  output logic [ACC_W-1:0] acc_o
);
  logic zero_d;
  assign zero_d = cont_clr_i | (auto_clr_i & upd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (zero_d) acc_o <= '0;
    else             acc_o <= acc_o + ftw_i;  // wraps mod 2^ACC_W
  end

  a_r6_cont_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_clr_i |=> (acc_o == '0));
  a_r8_auto_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_clr_i && upd_i) |=> (acc_o == '0));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_clr_i && !(auto_clr_i && upd_i)) |=> (acc_o == $past(acc_o) + $past(ftw_i)));
endmodule

// File: rtl/pa_phase_sum.sv
module pa_phase_sum #(
  parameter int unsigned PH_W = pa_pkg::PH_W_D
) (
  input  logic [PH_W-1:0] acc_top_i,
  input  logic [PH_W-1:0] pow_i,
  output logic [PH_W-1:0] phase_o
);
  assign phase_o = acc_top_i + pow_i;  // modulo 2^PH_W
endmodule

// File: rtl/phase_accum_core.sv
module phase_accum_core #(
  parameter int unsigned ACC_W = pa_pkg::ACC_W_D,
  parameter int unsigned PH_W  = pa_pkg::PH_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [PH_W-1:0]  pow_i,
  input  logic             cont_clr_i,
  input  logic             auto_clr_i,
  input  logic             update_i,
  output logic [PH_W-1:0]  phase_o
);
  localparam int unsigned TOP_LSB = ACC_W - PH_W;

  logic [ACC_W-1:0] ftw_act;
  logic [PH_W-1:0]  pow_act;
  logic [ACC_W-1:0] acc;

  pa_word_buf #(.ACC_W(ACC_W), .PH_W(PH_W)) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (update_i),
    .ftw_i (ftw_i),
    .pow_i (pow_i),
    .ftw_o (ftw_act),
    .pow_o (pow_act)
  );

  pa_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ftw_i     (ftw_act),
    .cont_clr_i(cont_clr_i),
    .auto_clr_i(auto_clr_i),
    .upd_i     (update_i),
    .acc_o     (acc)
  );

  pa_phase_sum #(.PH_W(PH_W)) u_sum (
    .acc_top_i(acc[ACC_W-1:TOP_LSB]),
    .pow_i    (pow_act),
    .phase_o  (phase_o)
  );

  // R7: clear wins, yet the offset still loads on the same strobe
  a_r7_clr_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_clr_i && update_i) |=> (phase_o == $past(pow_i)));
endmodule

// File: tb/phase_accum_core_tb.sv
module phase_accum_core_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ftw = '0;
  logic [13:0] pow = '0;
  logic        cc = 1'b0, ac = 1'b0, upd = 1'b0;
  logic [13:0] phase;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [13:0] ph; string tag; } exp_t;
  exp_t q[$];

  logic [31:0] m_acc = '0, m_ftw = '0;
  logic [13:0] m_pow = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_accum_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ftw_i(ftw), .pow_i(pow),
    .cont_clr_i(cc), .auto_clr_i(ac), .update_i(upd), .phase_o(phase)
  );

  task automatic check(input logic [13:0] act, input logic [13:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s phase_o actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus; model gives phase_o after the next edge
  task automatic step(input logic [31:0] f, input logic [13:0] p,
                      input logic c, input logic a, input logic u, input string tag);
    logic [31:0] nxt;
    exp_t e;
    ftw = f; pow = p; cc = c; ac = a; upd = u;
    if (c || (a && u)) nxt = '0;
    else               nxt = m_acc + m_ftw;
    m_acc = nxt;
    if (u) begin m_ftw = f; m_pow = p; end
    e.ph  = nxt[31:18] + m_pow;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(phase, e.ph, e.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phase, 14'h0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(phase, 14'h0, "R1 after release");

    // R3: word on ftw_i ignored without strobe
    for (int i = 0; i < 3; i++) step(32'h0100_0000, 14'h0, 0, 0, 0, "R3 no update");
    // R2/R3: load then accumulate, top bits step by 0x40
    step(32'h0100_0000, 14'h0, 0, 0, 1, "R3 load edge");
    for (int i = 0; i < 4; i++) step(32'h0100_0000, 14'h0, 0, 0, 0, "R2 accumulate");
    for (int i = 0; i < 2; i++) step(32'h7FFF_FFFF, 14'h0, 0, 0, 0, "R3 hold old word");
    // R2 wrap past 2^32
    step(32'hC000_0123, 14'h0, 0, 0, 1, "R9 update no zero");
    for (int i = 0; i < 6; i++) step(32'h0, 14'h0, 0, 0, 0, "R2 wrap");
    // R5 offset ignored until strobe, R4 sum wraps
    for (int i = 0; i < 2; i++) step(32'h0, 14'h1000, 0, 0, 0, "R5 no update");
    step(32'hC000_0123, 14'h3FFF, 0, 0, 1, "R4 offset load");
    for (int i = 0; i < 3; i++) step(32'h0, 14'h0, 0, 0, 0, "R4 offset sum");
    // R5 phase modulation: new offset every strobe
    for (int i = 0; i < 6; i++)
      step(32'hC000_0123, 14'(i * 14'h0A55), 0, 0, 1, "R5 modulation");
    // R6/R7 continuous clear, with loads during it
    step(32'h0040_0000, 14'h0100, 1, 0, 0, "R6 clear");
    step(32'h0040_0000, 14'h0200, 1, 0, 1, "R7 load during clear");
    step(32'h0040_0000, 14'h0300, 1, 1, 1, "R7 clear over auto");
    step(32'h0, 14'h0, 1, 0, 0, "R6 hold zero");
    for (int i = 0; i < 4; i++) step(32'h0, 14'h0, 0, 0, 0, "R6 resume");
    // R8 auto-clear on each strobe
    step(32'h0800_0000, 14'h0010, 0, 1, 1, "R8 zero on strobe");
    for (int i = 0; i < 3; i++) step(32'h0, 14'h0, 0, 1, 0, "R9 auto no strobe");
    step(32'h1000_0000, 14'h0020, 0, 1, 1, "R8 repeat strobe");
    for (int i = 0; i < 3; i++) step(32'h0, 14'h0, 0, 0, 0, "R8 new word used");
    step(32'h0300_0000, 14'h0020, 0, 0, 1, "R9 strobe without auto");
    for (int i = 0; i < 3; i++) step(32'h0, 14'h0, 0, 0, 0, "R2 after reload");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule